// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane

This block is the combinational heart of a small programmable logic device. Up to twenty logic signals (eleven dedicated inputs, one input that may instead serve as the device clock, and eight feedback signals returned from the output cells) are each presented to the array in true and inverted form, giving forty array lines. Ninety programmable product terms sample those lines. Each term ANDs together whichever lines its configuration connects.

Two terms are global asynchronous set and clear requests. Eight are per-output enable terms. The remaining eighty are shared unevenly among eight sum outputs, and each sum output is the OR of its own terms. The four middle outputs receive twelve terms each and the four outer outputs receive eight each.

The configuration is held in one long shift register. It is loaded serially while a load strobe is high and is held otherwise. The output cells, clock buffering and pins sit outside this block.

Top module: `pla_core`

## Requirements
- R1: Input index i drives array line 2i with its true value and line 2i+1 with its complement. The input indices are: ded_in[k] is index k (0..10), dual_in is index 11, and fb_in[k] is index 12+k.
- R2: A product term stores a used flag and a 40-bit line mask. When the flag is set, the term is the AND of every masked line. When the flag is clear, the term is 0 whatever its mask and the inputs.
- R3: A term with its used flag set and an all-zero mask evaluates to 1.
- R4: Term 0 drives aset_term, term 1 drives aclr_term, terms 2..9 drive oe_term[0..7] in order, and terms 10..89 are sum terms.
- R5: Sum terms are allocated consecutively from term 10 in output order, 8 terms each to outputs 0, 1, 6 and 7 and 12 terms each to outputs 2..5. sum_out[o] is the OR of exactly its own terms, so term 37 belongs to output 2 and term 38 to output 3.
- R6: The configuration image is 3691 bits wide. Bit 0 is the clock-mode flag. Term t occupies bits 1+41t .. 41+41t: bit 1+41t is the used flag, and bit 2+41t+L is the mask bit for line L.
- R7: On each rising clk edge with cfg_load high, the image shifts up by one bit, cfg_sin enters bit 0, and cfg_sout shows image bit 3690. With cfg_load low the image and all outputs are held whatever cfg_sin does.
- R8: When the clock-mode flag is set, lines 22 and 23 are both forced to 0, so any term that connects either line evaluates to 0 whatever dual_in is.
- R9: An active-low rst_n clears the whole image asynchronously, leaving every term output and cfg_sout at 0.
- R10: All term and sum outputs follow the inputs combinationally, with no clock edge between an input change and the output change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (top image bit) |
| ded_in | input | 11 | Dedicated logic inputs |
| dual_in | input | 1 | Input shared with the clock function |
| fb_in | input | 8 | Feedback signals from the output cells |
| aset_term | output | 1 | Global asynchronous set term |
| aclr_term | output | 1 | Global asynchronous clear term |
| oe_term | output | 8 | Per-output enable terms |
| sum_out | output | 8 | OR of each output's sum terms |

## Verification
One configuration is applied to a table of input patterns. The patterns are chosen so that each connected line switches its term alone. Pairs such as d3 with and without fb7 separate a true-line connection from a complement-line connection. The term pair on each side of an output boundary (17/18, 37/38) shows whether the uneven allocation sends each term to the right OR gate, and an unused term with a non-empty mask shows whether the used flag gates the term. A second configuration with the clock-mode flag set connects both lines of the shared input and toggles dual_in, which separates forced lines from ordinary ones.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int N_DED       = 11;
    localparam int N_FB        = 8;
    localparam int DUAL_IDX    = N_DED;
    localparam int N_IN        = N_DED + 1 + N_FB;
    localparam int N_LINES     = 2 * N_IN;
    localparam int N_OUT       = 8;
    localparam int SMALL_TERMS = 8;
    localparam int LARGE_TERMS = 12;
    localparam int N_EDGE_OUT  = 4;
    localparam int N_CTRL      = 2 + N_OUT;
    localparam int N_SUM       = N_EDGE_OUT * SMALL_TERMS + (N_OUT - N_EDGE_OUT) * LARGE_TERMS;
    localparam int N_TERMS     = N_CTRL + N_SUM;
    localparam int TERM_W      = 1 + N_LINES;
    localparam int CFG_W       = 1 + N_TERMS * TERM_W;

    // outer outputs (two at each end) receive the smaller share
    function automatic int terms_of(input int o);
        return (o >= N_EDGE_OUT / 2 && o < N_OUT - N_EDGE_OUT / 2) ? LARGE_TERMS : SMALL_TERMS;
    endfunction

    // first sum-term index (relative to the sum region) owned by output o
    function automatic int sum_offset(input int o);
        int acc;
        acc = 0;
        for (int k = 0; k < o; k++) acc += terms_of(k);
        return acc;
    endfunction

    typedef struct packed {
        logic [CFG_W-1:0] img;
    } chain_st_t;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sin,
    output logic             sout,
    output logic [CFG_W-1:0] img
);
    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.img = {st_q.img[CFG_W-2:0], sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign img  = st_q.img;
    assign sout = st_q.img[CFG_W-1];
endmodule

// File: rtl/pla_line_drv.sv
module pla_line_drv
    import pla_pkg::*;
(
    input  logic [N_DED-1:0]   ded_in,
    input  logic               dual_in,
    input  logic [N_FB-1:0]    fb_in,
    input  logic               clk_mode,
    output logic [N_LINES-1:0] lines
);
    logic [N_IN-1:0] raw;
    assign raw = {fb_in, dual_in, ded_in};

    for (genvar i = 0; i < N_IN; i++) begin : g_pair
        if (i == DUAL_IDX) begin : g_shared
            assign lines[2*i]   = ~clk_mode &  raw[i];
            assign lines[2*i+1] = ~clk_mode & ~raw[i];
        end else begin : g_plain
            assign lines[2*i]   =  raw[i];
            assign lines[2*i+1] = ~raw[i];
        end
    end
endmodule

// File: rtl/pla_pterm.sv
module pla_pterm #(
    parameter int NL = 40
) (
    input  logic [NL-1:0] lines,
    input  logic [NL-1:0] mask,
    input  logic          used,
    output logic          hit
);
    // unconnected lines read as 1 so they drop out of the AND
    assign hit = used & (&(lines | ~mask));
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
(
    input  logic [N_SUM-1:0] sum_terms,
    output logic [N_OUT-1:0] sum_out
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int BASE = sum_offset(o);
        localparam int CNT  = terms_of(o);
        assign sum_out[o] = |sum_terms[BASE +: CNT];
    end
endmodule

// File: rtl/pla_core.sv
module pla_core
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_sin,
    output logic             cfg_sout,
    input  logic [N_DED-1:0] ded_in,
    input  logic             dual_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic             aset_term,
    output logic             aclr_term,
    output logic [N_OUT-1:0] oe_term,
    output logic [N_OUT-1:0] sum_out
);
    logic [CFG_W-1:0]   cfg_img;
    logic               clk_mode;
    logic [N_LINES-1:0] lines;
    logic [N_TERMS-1:0] term_hit;

    pla_cfg_chain u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .sin   (cfg_sin),
        .sout  (cfg_sout),
        .img   (cfg_img)
    );

    assign clk_mode = cfg_img[0];

    pla_line_drv u_lines (
        .ded_in   (ded_in),
        .dual_in  (dual_in),
        .fb_in    (fb_in),
        .clk_mode (clk_mode),
        .lines    (lines)
    );

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        localparam int FLD = 1 + t * TERM_W;
        pla_pterm #(.NL(N_LINES)) u_pt (
            .lines (lines),
            .mask  (cfg_img[FLD+1 +: N_LINES]),
            .used  (cfg_img[FLD]),
            .hit   (term_hit[t])
        );
    end

    assign aset_term = term_hit[0];
    assign aclr_term = term_hit[1];
    assign oe_term   = term_hit[2 +: N_OUT];

    pla_or_plane u_or (
        .sum_terms (term_hit[N_CTRL +: N_SUM]),
        .sum_out   (sum_out)
    );
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk
    import pla_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_load,
    input logic               cfg_sout,
    input logic               aset_term,
    input logic               aclr_term,
    input logic [N_OUT-1:0]   oe_term,
    input logic [N_OUT-1:0]   sum_out,
    input logic               clk_mode,
    input logic [N_LINES-1:0] lines
);
    logic [N_IN-1:0] pair_ok;
    always_comb begin
        for (int i = 0; i < N_IN; i++) pair_ok[i] = lines[2*i] ^ lines[2*i+1];
    end

    assert_pairs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_mode |-> &pair_ok);

    assert_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mode |-> (lines[2*DUAL_IDX+1 -: 2] == 2'b00));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_sout));

    assert_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sum_out == '0 && oe_term == '0 && !aset_term && !aclr_term && !cfg_sout));
endmodule

bind pla_core pla_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_sout  (cfg_sout),
    .aset_term (aset_term),
    .aclr_term (aclr_term),
    .oe_term   (oe_term),
    .sum_out   (sum_out),
    .clk_mode  (clk_mode),
    .lines     (lines)
);

// File: tb/pla_core_tb.sv
module pla_core_tb_top;
    localparam int CW  = 3691;
    localparam int TW  = 41;
    localparam int NV  = 9;

    // {ded[10:0], dual, fb[7:0], aset, aclr, oe[7:0], sum[7:0]}
    localparam logic [37:0] VEC [NV] = '{
        {11'h000, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h80},
        {11'h001, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 8'h80},
        {11'h003, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h80},
        {11'h004, 1'b0, 8'hC0, 1'b0, 1'b1, 8'h00, 8'h01},
        {11'h008, 1'b0, 8'h80, 1'b0, 1'b1, 8'h00, 8'h00},
        {11'h008, 1'b0, 8'h41, 1'b0, 1'b1, 8'h02, 8'h01},
        {11'h030, 1'b1, 8'h40, 1'b0, 1'b1, 8'h00, 8'h2C},
        {11'h7FF, 1'b1, 8'hFF, 1'b0, 1'b1, 8'h02, 8'h2D},
        {11'h001, 1'b0, 8'h01, 1'b1, 1'b1, 8'h02, 8'h80}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_sin = 1'b0;
    logic        cfg_sout;
    logic [10:0] ded_in = '0;
    logic        dual_in = 1'b0;
    logic [7:0]  fb_in = '0;
    logic        aset_term, aclr_term;
    logic [7:0]  oe_term, sum_out;

    logic [CW-1:0] img;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pla_core dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sin(cfg_sin),
        .cfg_sout(cfg_sout), .ded_in(ded_in), .dual_in(dual_in), .fb_in(fb_in),
        .aset_term(aset_term), .aclr_term(aclr_term), .oe_term(oe_term), .sum_out(sum_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic use_term(input int t);
        img[1 + TW*t] = 1'b1;
    endtask

    task automatic tie(input int t, input int line);
        img[2 + TW*t + line] = 1'b1;
    endtask

    task automatic shift_in();
        for (int b = CW - 1; b >= 0; b--) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_sin  = img[b];
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_sin  = 1'b0;
    endtask

    task automatic apply(input logic [10:0] d, input logic du, input logic [7:0] f);
        ded_in = d; dual_in = du; fb_in = f;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        apply(11'h7FF, 1'b1, 8'hFF);
        // R9: cleared image gives zero outputs even with all inputs high
        check("R9 sum", sum_out, 0);
        check("R9 oe", oe_term, 0);
        check("R9 aset", aset_term, 0);
        check("R9 aclr", aclr_term, 0);
        check("R9 sout", cfg_sout, 0);
        rst_n = 1'b1;

        // configuration A (R4, R5, R6 layout)
        img = '0;
        use_term(0); tie(0, 0); tie(0, 3);
        use_term(1);                         // R3 empty mask
        use_term(3); tie(3, 24);             // oe1 = fb0
        tie(18, 4);                          // R2 unused term with a mask
        use_term(10); tie(10, 4);
        use_term(17); tie(17, 6); tie(17, 39);
        use_term(37); tie(37, 8);            // last of output 2
        use_term(38); tie(38, 10);           // first of output 3
        use_term(73); tie(73, 22);
        use_term(89); tie(89, 37); tie(89, 39);
        shift_in();
        #1;
        check("R7 sout top bit", cfg_sout, 1);

        // table walk: R1 R2 R3 R4 R5 R10 (no clock edge between apply and check)
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][37:27], VEC[v][26], VEC[v][25:18]);
            check("R4 aset", aset_term, VEC[v][17]);
            check("R3 aclr", aclr_term, VEC[v][16]);
            check("R2 oe", oe_term, VEC[v][15:8]);
            check("R5 sum", sum_out, VEC[v][7:0]);
        end

        // R7: load low, toggling cfg_sin changes nothing
        apply(11'h7FF, 1'b1, 8'hFF);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cfg_sin = k[0];
        end
        #1;
        check("R7 hold sum", sum_out, 8'h2D);
        check("R7 hold oe", oe_term, 8'h02);
        check("R7 hold sout", cfg_sout, 1);

        // R9: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async sum", sum_out, 0);
        check("R9 async aclr", aclr_term, 0);
        check("R9 async sout", cfg_sout, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // configuration B: clock mode, both shared-input lines tied (R8)
        img = '0;
        img[0] = 1'b1;
        use_term(72); tie(72, 23);
        use_term(73); tie(73, 22);
        use_term(10); tie(10, 4);
        shift_in();
        apply(11'h000, 1'b0, 8'h00);
        check("R8 dual low", sum_out, 8'h00);
        apply(11'h000, 1'b1, 8'h00);
        check("R8 dual high", sum_out, 8'h00);
        apply(11'h004, 1'b1, 8'h00);
        check("R8 other lines live", sum_out, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule